// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Engine

This block is the master side of an I2C port that shares its bus with other masters. On host request it generates START, repeated START, STOP, a one-bit acknowledge and an 8-bit transmit. SCL and SDA are driven open-drain: the block only ever pulls a line low or lets it float. Every bit slot is built from four equal phases timed by a programmable divider. The phases are SCL low with SDA set up, SCL released, SCL high with the comparison point, and SCL pulled low again.

In every slot the block compares the SDA level it intended with the synchronized bus level while SCL is high. If it released SDA but finds it low, another master has won arbitration. The block then raises a sticky collision flag and drops every pending request and any half-sent byte. It lets go of both lines and falls back to idle.

A bus watcher runs at all times. It detects START and STOP on the bus and keeps two status bits, and from these derives whether the bus is free. START and STOP events raise the general port interrupt, so after a lost arbitration the host learns when it may try again.

Top module: `i2c_arb_master`

## Requirements
- R1: After reset both line drivers are released, and `bcol_irq`, `port_irq`, `buf_full`, `owner` and `req_pend` are all 0, with `bus_free` = 1.
- R2: A START request on a free bus produces SDA falling while SCL is high, then holds SCL low. The block then owns the bus (`owner` = 1).
- R3: A byte written to `tx_byte` is sent MSB first, one bit per SCL high pulse, and SDA never changes while SCL is high. `buf_full` is 1 from the write until the last bit ends, and completion sets `port_irq`.
- R4: If the block released SDA but samples it low while SCL is high, it sets `bcol_irq`, releases SCL and SDA, and returns to idle without ownership.
- R5: A collision during a transmit clears `buf_full`. The next byte written after a new START is sent from its MSB.
- R6: A collision during repeated START, STOP or acknowledge aborts that sequence and clears all bits of `req_pend` (bit0 START, bit1 repeated START, bit2 STOP, bit3 acknowledge).
- R7: A bus START (SDA falls, SCL high) sets `start_seen` and clears `stop_seen`; a bus STOP (SDA rises, SCL high) does the reverse. `bus_free` is 1 when `stop_seen` is 1 or both bits are 0.
- R8: `port_irq` is set by every detected bus START or STOP, including a STOP made by another master after a collision. It is cleared by `irq_clr`.
- R9: `bcol_irq` stays 1 until a `bcol_clr` pulse clears it.
- R10: A START request while the bus is not free is dropped and sets `bcol_irq` without driving either line. Repeated START, STOP and acknowledge requests made without ownership are dropped.
- R11: A STOP sequence ends with both lines released, `owner` = 0 and `bus_free` = 1.
- R12: An acknowledge request sends the level given on `ack_level` for exactly one SCL pulse.
- R13: SCL stays released for two phases, 2*DIV clock cycles, in each data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | Request a START (pulse) |
| cmd_rstart | input | 1 | Request a repeated START (pulse) |
| cmd_stop | input | 1 | Request a STOP (pulse) |
| cmd_ack | input | 1 | Request an acknowledge bit (pulse) |
| ack_level | input | 1 | Level sent by the acknowledge, captured with cmd_ack |
| tx_we | input | 1 | Write tx_byte to the transmit buffer |
| tx_byte | input | DATA_W | Byte to transmit |
| bcol_clr | input | 1 | Clear the collision flag |
| irq_clr | input | 1 | Clear the port interrupt flag |
| scl_in | input | 1 | SCL level on the bus |
| sda_in | input | 1 | SDA level on the bus |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| req_pend | output | 4 | Pending requests {ack, stop, rstart, start} |
| buf_full | output | 1 | Transmit buffer holds an unsent byte |
| bcol_irq | output | 1 | Sticky bus collision flag |
| port_irq | output | 1 | Sticky port interrupt flag |
| start_seen | output | 1 | Last bus condition seen was a START |
| stop_seen | output | 1 | Last bus condition seen was a STOP |
| bus_free | output | 1 | Bus may be claimed |
| owner | output | 1 | Block currently owns the bus |

## Verification
The hard situation is a collision in the middle of a byte or a control sequence, since no port can force one. The bench wires a second open-drain master onto the modelled bus. That rival pulls SDA low while SCL is low, either after a chosen number of SCL falls inside a byte of ones or while the block holds the bus before a repeated START, STOP or NACK. The rival then lets SDA rise while SCL floats high, which produces the bus STOP that must free the bus and raise the port interrupt.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_HOLD, ST_START, ST_RSTART, ST_STOP, ST_ACK, ST_TX
   } arb_state_e;

   localparam int REQ_START  = 0;
   localparam int REQ_RSTART = 1;
   localparam int REQ_STOP   = 2;
   localparam int REQ_ACK    = 3;
   localparam int REQ_W      = 4;
endpackage

// File: rtl/i2c_phase_tick.sv
module i2c_phase_tick #(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [CW-1:0] cnt;

   generate
      if (DIV < 4) begin : g_bad_div
         $error("i2c_phase_tick: DIV must be at least 4");
      end
      if ((DIV & (DIV - 1)) == 0) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt <= '0;
            else if (!en) cnt <= '0;
            else          cnt <= cnt + 1'b1;
         end
         assign tick = en && (&cnt);
      end else begin : g_cmp
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt <= '0;
            else if (!en)          cnt <= '0;
            else if (cnt == LAST)  cnt <= '0;
            else                   cnt <= cnt + 1'b1;
         end
         assign tick = en && (cnt == LAST);
      end
   endgenerate

   p_tick_gap_r13: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/i2c_line_watch.sv
module i2c_line_watch #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic start_det,
   output logic stop_det,
   output logic start_seen,
   output logic stop_seen,
   output logic bus_free
);
   logic [SYNC_STAGES-1:0] scl_q, sda_q;
   logic                   scl_d, sda_d;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("i2c_line_watch: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_q <= {scl_q[SYNC_STAGES-2:0], scl_in};
         sda_q <= {sda_q[SYNC_STAGES-2:0], sda_in};
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_s     = scl_q[SYNC_STAGES-1];
   assign sda_s     = sda_q[SYNC_STAGES-1];
   assign start_det = scl_s && scl_d && sda_d && !sda_s;
   assign stop_det  = scl_s && scl_d && !sda_d && sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_seen <= 1'b0;
         stop_seen  <= 1'b0;
      end else if (start_det) begin
         start_seen <= 1'b1;
         stop_seen  <= 1'b0;
      end else if (stop_det) begin
         start_seen <= 1'b0;
         stop_seen  <= 1'b1;
      end
   end

   assign bus_free = stop_seen || (!start_seen && !stop_seen);

   p_seen_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_seen, stop_seen}));
   p_free_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> bus_free);
   p_busy_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !bus_free);
endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master
   import i2c_arb_pkg::*;
#(
   parameter int DIV         = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_rstart,
   input  logic              cmd_stop,
   input  logic              cmd_ack,
   input  logic              ack_level,
   input  logic              tx_we,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              bcol_clr,
   input  logic              irq_clr,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_drive_low,
   output logic              sda_drive_low,
   output logic [REQ_W-1:0]  req_pend,
   output logic              buf_full,
   output logic              bcol_irq,
   output logic              port_irq,
   output logic              start_seen,
   output logic              stop_seen,
   output logic              bus_free,
   output logic              owner
);
   localparam int            BW       = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("i2c_arb_master: DATA_W must be at least 2");
      end
   endgenerate

   arb_state_e        st;
   logic [1:0]        ph;
   logic [BW-1:0]     bitn;
   logic [DATA_W-1:0] shreg;
   logic              ack_q;
   logic              tick, op_en;
   logic              scl_s, sda_s, mon_start, mon_stop;
   logic              scl_rel, sda_rel, chk_pt, collision;

   assign op_en = (st == ST_START) || (st == ST_RSTART) || (st == ST_STOP) ||
                  (st == ST_ACK) || (st == ST_TX);

   i2c_phase_tick #(.DIV(DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(op_en), .tick(tick)
   );

   i2c_line_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_s(scl_s), .sda_s(sda_s), .start_det(mon_start), .stop_det(mon_stop),
      .start_seen(start_seen), .stop_seen(stop_seen), .bus_free(bus_free)
   );

   // Intended line levels per state and phase (1 = released).
   always_comb begin
      scl_rel = 1'b1;
      sda_rel = 1'b1;
      chk_pt  = 1'b0;
      unique case (st)
         ST_IDLE: ;
         ST_HOLD: scl_rel = 1'b0;
         ST_START: begin
            scl_rel = (ph != 2'd3);
            sda_rel = (ph < 2'd2);
            chk_pt  = (ph == 2'd1);
         end
         ST_RSTART: begin
            scl_rel = (ph == 2'd1) || (ph == 2'd2);
            sda_rel = (ph < 2'd2);
            chk_pt  = (ph == 2'd1);
         end
         ST_STOP: begin
            scl_rel = (ph != 2'd0);
            sda_rel = (ph >= 2'd2);
            chk_pt  = (ph == 2'd3);
         end
         ST_ACK: begin
            scl_rel = (ph == 2'd1) || (ph == 2'd2);
            sda_rel = ack_q;
            chk_pt  = (ph == 2'd2);
         end
         ST_TX: begin
            scl_rel = (ph == 2'd1) || (ph == 2'd2);
            sda_rel = shreg[DATA_W-1];
            chk_pt  = (ph == 2'd2);
         end
         default: ;
      endcase
   end

   assign collision     = tick && chk_pt && sda_rel && scl_s && !sda_s;
   assign scl_drive_low = !scl_rel;
   assign sda_drive_low = !sda_rel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         ph       <= '0;
         bitn     <= '0;
         shreg    <= '0;
         ack_q    <= 1'b0;
         buf_full <= 1'b0;
         bcol_irq <= 1'b0;
         port_irq <= 1'b0;
         req_pend <= '0;
         owner    <= 1'b0;
      end else begin
         if (bcol_clr)             bcol_irq <= 1'b0;
         if (irq_clr)              port_irq <= 1'b0;
         if (mon_start || mon_stop) port_irq <= 1'b1;
         if (cmd_start)  req_pend[REQ_START]  <= 1'b1;
         if (cmd_rstart) req_pend[REQ_RSTART] <= 1'b1;
         if (cmd_stop)   req_pend[REQ_STOP]   <= 1'b1;
         if (cmd_ack) begin
            req_pend[REQ_ACK] <= 1'b1;
            ack_q             <= ack_level;
         end
         if (tx_we && !buf_full) begin
            shreg    <= tx_byte;
            buf_full <= 1'b1;
         end

         if (collision) begin
            st       <= ST_IDLE;
            ph       <= '0;
            owner    <= 1'b0;
            req_pend <= '0;
            buf_full <= 1'b0;
            bcol_irq <= 1'b1;
         end else if (tick) begin
            ph <= ph + 2'd1;
            if (ph == 2'd3) begin
               unique case (st)
                  ST_START, ST_RSTART: begin
                     st                   <= ST_HOLD;
                     owner                <= 1'b1;
                     req_pend[REQ_START]  <= 1'b0;
                     req_pend[REQ_RSTART] <= 1'b0;
                     port_irq             <= 1'b1;
                  end
                  ST_STOP: begin
                     st                 <= ST_IDLE;
                     owner              <= 1'b0;
                     req_pend[REQ_STOP] <= 1'b0;
                     port_irq           <= 1'b1;
                  end
                  ST_ACK: begin
                     st                <= ST_HOLD;
                     req_pend[REQ_ACK] <= 1'b0;
                     port_irq          <= 1'b1;
                  end
                  ST_TX: begin
                     shreg <= {shreg[DATA_W-2:0], 1'b0};
                     bitn  <= bitn + 1'b1;
                     if (bitn == LAST_BIT) begin
                        st       <= ST_HOLD;
                        buf_full <= 1'b0;
                        port_irq <= 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
         end else if (st == ST_IDLE) begin
            req_pend[REQ_W-1:1] <= '0;
            if (req_pend[REQ_START]) begin
               if (bus_free) begin
                  st <= ST_START;
                  ph <= '0;
               end else begin
                  req_pend[REQ_START] <= 1'b0;
                  bcol_irq            <= 1'b1;
               end
            end
         end else if (st == ST_HOLD) begin
            req_pend[REQ_START] <= 1'b0;
            ph                  <= '0;
            if (req_pend[REQ_RSTART])    st <= ST_RSTART;
            else if (req_pend[REQ_STOP]) st <= ST_STOP;
            else if (req_pend[REQ_ACK])  st <= ST_ACK;
            else if (buf_full) begin
               st   <= ST_TX;
               bitn <= '0;
            end
         end
      end
   end

   p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      collision |=> (!scl_drive_low && !sda_drive_low && !owner));
   p_bcol_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      collision |=> bcol_irq);
   p_bufclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (collision && st == ST_TX) |=> !buf_full);
   p_req_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      collision |=> (req_pend == '0));
   p_sda_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TX && !$stable(sda_drive_low)) |-> scl_drive_low);
   p_bcol_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bcol_irq && !bcol_clr) |=> bcol_irq);
   p_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && req_pend[REQ_START] && !bus_free) |=> (bcol_irq && st == ST_IDLE));
endmodule

// File: tb/test_i2c_arb_master.sv
module test_i2c_arb_master;
   localparam int DIV = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_start = 0, cmd_rstart = 0, cmd_stop = 0, cmd_ack = 0, ack_level = 0;
   logic       tx_we = 0, bcol_clr = 0, irq_clr = 0;
   logic [7:0] tx_byte = '0;
   logic       rival_sda = 0, rival_scl = 0;
   logic       scl_drive_low, sda_drive_low, buf_full, bcol_irq, port_irq;
   logic       start_seen, stop_seen, bus_free, owner;
   logic [3:0] req_pend;
   logic       scl_bus, sda_bus;

   int tests = 0, fails = 0, cyc = 0;
   int capn = 0, viol = 0, starts = 0, run = 0, last_run = 0, sclfalls = 0;
   logic [7:0] cap = '0;
   logic       p_scl = 1'b1, p_sda = 1'b1;

   always #2.5 clk = ~clk;

   assign scl_bus = !(scl_drive_low || rival_scl);
   assign sda_bus = !(sda_drive_low || rival_sda);

   i2c_arb_master #(.DIV(DIV)) i_i2c_arb_master (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_rstart(cmd_rstart),
      .cmd_stop(cmd_stop), .cmd_ack(cmd_ack), .ack_level(ack_level),
      .tx_we(tx_we), .tx_byte(tx_byte), .bcol_clr(bcol_clr), .irq_clr(irq_clr),
      .scl_in(scl_bus), .sda_in(sda_bus), .scl_drive_low(scl_drive_low),
      .sda_drive_low(sda_drive_low), .req_pend(req_pend), .buf_full(buf_full),
      .bcol_irq(bcol_irq), .port_irq(port_irq), .start_seen(start_seen),
      .stop_seen(stop_seen), .bus_free(bus_free), .owner(owner)
   );

   // Bus observer, sampled away from the active edge.
   always @(negedge clk) begin
      cyc++;
      if (scl_bus && !p_scl) begin
         cap = {cap[6:0], sda_bus};
         capn++;
      end
      if (!scl_bus && p_scl) sclfalls++;
      if (scl_bus && p_scl && (sda_bus != p_sda)) begin
         if (!sda_bus) starts++;
         else if (owner) viol++;
      end
      if (scl_drive_low) begin
         if (run != 0) last_run = run;
         run = 0;
      end else run++;
      p_scl = scl_bus;
      p_sda = sda_bus;
   end

   task automatic chk(input string rq, input string what, input int act, input int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_start();  cmd_start = 1;  @(negedge clk); cmd_start = 0;  endtask
   task automatic pulse_rstart(); cmd_rstart = 1; @(negedge clk); cmd_rstart = 0; endtask
   task automatic pulse_stop();   cmd_stop = 1;   @(negedge clk); cmd_stop = 0;   endtask
   task automatic pulse_bclr();   bcol_clr = 1;   @(negedge clk); bcol_clr = 0;   endtask
   task automatic pulse_iclr();   irq_clr = 1;    @(negedge clk); irq_clr = 0;    endtask
   task automatic pulse_ack(input logic lv);
      ack_level = lv; cmd_ack = 1; @(negedge clk); cmd_ack = 0;
   endtask
   task automatic write_tx(input logic [7:0] b);
      tx_byte = b; tx_we = 1; @(negedge clk); tx_we = 0;
   endtask

   task automatic do_start();
      pulse_start();
      for (int i = 0; i < 2000 && !owner; i++) @(negedge clk);
   endtask

   task automatic do_stop();
      pulse_stop();
      for (int i = 0; i < 2000 && owner; i++) @(negedge clk);
      idle(6);
   endtask

   task automatic wait_bcol();
      for (int i = 0; i < 2000 && !bcol_irq; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      idle(2);
      chk("R1", "scl_drive_low", scl_drive_low, 0);
      chk("R1", "sda_drive_low", sda_drive_low, 0);
      chk("R1", "flags", {bcol_irq, port_irq, buf_full, owner}, 0);
      chk("R1", "req_pend", req_pend, 0);
      chk("R1", "bus_free", bus_free, 1);
   endtask

   task automatic t_drop();
      pulse_stop();
      idle(20);
      chk("R10", "req dropped without owner", req_pend, 0);
      chk("R10", "lines untouched", {scl_drive_low, sda_drive_low, owner}, 0);
   endtask

   task automatic t_start();
      int s0;
      s0 = starts;
      pulse_iclr();
      do_start();
      idle(4);
      chk("R2", "owner", owner, 1);
      chk("R2", "scl held low", scl_drive_low, 1);
      chk("R2", "bus start seen", starts - s0, 1);
      chk("R7", "start/stop seen", {start_seen, stop_seen, bus_free}, 3'b100);
      chk("R8", "port_irq after start", port_irq, 1);
   endtask

   task automatic t_tx(input logic [7:0] b);
      pulse_iclr();
      capn = 0; viol = 0;
      write_tx(b);
      chk("R3", "buf_full after write", buf_full, 1);
      for (int i = 0; i < 2000 && buf_full; i++) @(negedge clk);
      idle(2);
      chk("R3", "captured byte", cap, b);
      chk("R3", "bit count", capn, 8);
      chk("R3", "sda change with scl high", viol, 0);
      chk("R3", "buf_full after byte", buf_full, 0);
      chk("R3", "port_irq on completion", port_irq, 1);
      chk("R13", "scl high cycles", last_run, 2 * DIV);
   endtask

   task automatic t_ack();
      capn = 0;
      pulse_ack(1'b0);
      for (int i = 0; i < 2000 && req_pend[3]; i++) @(negedge clk);
      idle(2);
      chk("R12", "ack bit count", capn, 1);
      chk("R12", "ack level", cap[0], 0);
      chk("R12", "still owner", owner, 1);
   endtask

   task automatic t_stop();
      do_stop();
      chk("R11", "lines released", {scl_drive_low, sda_drive_low, owner}, 0);
      chk("R11", "bus_free", bus_free, 1);
      chk("R7", "stop seen", {start_seen, stop_seen}, 2'b01);
   endtask

   task automatic t_busy_start();
      rival_sda = 1;
      idle(6);
      chk("R7", "rival start busy", {start_seen, bus_free}, 2'b10);
      pulse_start();
      idle(6);
      chk("R10", "bcol on refused start", bcol_irq, 1);
      chk("R10", "req cleared", req_pend, 0);
      chk("R10", "no lines driven", {scl_drive_low, sda_drive_low, owner}, 0);
      rival_sda = 0;
      idle(6);
      chk("R7", "free after rival stop", bus_free, 1);
      pulse_bclr();
      chk("R9", "bcol cleared", bcol_irq, 0);
   endtask

   task automatic t_col_tx();
      int f0;
      do_start();
      pulse_iclr();
      f0 = sclfalls;
      write_tx(8'hFF);
      for (int i = 0; i < 2000 && (sclfalls - f0) < 2; i++) @(negedge clk);
      rival_sda = 1;
      wait_bcol();
      idle(1);
      chk("R4", "bcol set", bcol_irq, 1);
      chk("R4", "lines released", {scl_drive_low, sda_drive_low, owner}, 0);
      chk("R5", "buf_full cleared", buf_full, 0);
      chk("R5", "req cleared", req_pend, 0);
      pulse_iclr();
      rival_sda = 0;
      idle(6);
      chk("R8", "port_irq on rival stop", port_irq, 1);
      chk("R7", "free after rival stop", {stop_seen, bus_free}, 2'b11);
      idle(10);
      chk("R9", "bcol sticky", bcol_irq, 1);
      pulse_bclr();
      chk("R9", "bcol cleared", bcol_irq, 0);
      do_start();
      capn = 0;
      write_tx(8'hA5);
      for (int i = 0; i < 2000 && buf_full; i++) @(negedge clk);
      idle(2);
      chk("R5", "restart from MSB", cap, 8'hA5);
      chk("R5", "restart bit count", capn, 8);
      do_stop();
   endtask

   task automatic t_col_seq(input int kind);
      do_start();
      rival_sda = 1;
      idle(2);
      if (kind == 0) pulse_rstart();
      else if (kind == 1) pulse_stop();
      else pulse_ack(1'b1);
      wait_bcol();
      idle(1);
      chk("R6", "bcol on sequence collision", bcol_irq, 1);
      chk("R6", "req cleared", req_pend, 0);
      chk("R6", "aborted, released", {scl_drive_low, sda_drive_low, owner}, 0);
      rival_sda = 0;
      idle(6);
      pulse_bclr();
      chk("R7", "free again", bus_free, 1);
   endtask

   initial begin
      for (int i = 0; i < 150000; i++) @(negedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1;
      t_reset();
      t_drop();
      t_start();
      t_tx(8'hC6);
      t_ack();
      t_tx(8'h3A);
      t_stop();
      t_busy_start();
      t_col_tx();
      t_col_seq(0);
      t_col_seq(1);
      t_col_seq(2);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule